// File: doc/BRIEF.md
# Port Bring-Up and Tear-Down Sequencer

This block sits beside a multi-port Ethernet MAC and owns the per-port control levels that the MAC, its transmit FIFO and its receive FIFO obey: a port enable, three soft resets (transmit FIFO, MAC core, receive FIFO) and a transmit flush. Software or link-monitoring logic presents one-cycle pulses asking for a port to be enabled, disabled, or torn down because its link dropped. The sequencer queues these requests per port and works through one port at a time. Each port moves through a fixed series of single control changes, one change per step.

Bringing a port up sets the enable bit first and then releases the transmit FIFO reset, the flush, the MAC reset and the receive FIFO reset, in that order. Tearing a port down clears the enable bit and asserts the transmit FIFO reset. It then waits a programmable drain time so that a frame already leaving the port can finish, and then asserts flush, MAC reset and receive FIFO reset. When the teardown comes from a lost link, nothing is left to drain and the wait is skipped. After reset every port is held down, so the first sequence any port needs is a bring-up.

Top module: `portctl_sequencer`

## Requirements
- R1: While reset is low and after it, every bit of `port_en_o` is 0, every bit of `txf_rst_o`, `tx_flush_o`, `mac_rst_o` and `rxf_rst_o` is 1, and `busy_o` and `done_o` are all 0, until a request is served. Bit n of every vector belongs to port n.
- R2: An enable request on a down port (`port_en_o[n]`=0) presented in cycle c sets `port_en_o[n]` in cycle c+3. In each of the next four cycles exactly one further change appears, in this order: `txf_rst_o[n]` to 0, `tx_flush_o[n]` to 0, `mac_rst_o[n]` to 0, `rxf_rst_o[n]` to 0.
- R3: A disable request on an up port presented in cycle c clears `port_en_o[n]` in cycle c+3 and sets `txf_rst_o[n]` in cycle c+4. It then sets `tx_flush_o[n]`, `mac_rst_o[n]` and `rxf_rst_o[n]`, in that order, in consecutive cycles.
- R4: For a disable request, `tx_flush_o[n]` rises DRAIN_CYCLES+2 cycles after `txf_rst_o[n]` rises.
- R5: For a link-drop request, the drain wait is skipped, so `tx_flush_o[n]` rises one cycle after `txf_rst_o[n]`. A link drop pending together with a disable also skips the wait.
- R6: Across all ports and all five controls, at most one output bit changes per cycle, and only a port whose sequence is running changes.
- R7: At most one bit of `busy_o` is high at any time.
- R8: When several ports have pending requests, the lowest-numbered port is served first. A second port starts one cycle after the first port's done pulse.
- R9: If a disable or link drop and an enable are both pending for one port, the teardown is chosen and all of that port's pending requests are cleared. On a port that is already down, this means that nothing happens.
- R10: A request that matches the port's current enable state is discarded: an enable on an up port, or a disable or link drop on a down port. No busy, no done and no control change follow.
- R11: `busy_o[n]` is high from cycle c+2 through the cycle before the last control change. `done_o[n]` is a one-cycle pulse in the cycle in which the last control change becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req_i | input | NUM_PORTS | One-cycle enable request, bit per port |
| dis_req_i | input | NUM_PORTS | One-cycle disable request (with drain wait), bit per port |
| link_drop_i | input | NUM_PORTS | One-cycle link-lost teardown request (no drain wait), bit per port |
| port_en_o | output | NUM_PORTS | Port enable level |
| txf_rst_o | output | NUM_PORTS | Transmit FIFO soft reset |
| tx_flush_o | output | NUM_PORTS | Transmit flush |
| mac_rst_o | output | NUM_PORTS | MAC core soft reset |
| rxf_rst_o | output | NUM_PORTS | Receive FIFO soft reset |
| busy_o | output | NUM_PORTS | High while that port's sequence runs |
| done_o | output | NUM_PORTS | One-cycle pulse when that port's last step is visible |

## Verification
Every cycle, the assertions check three things: no more than one control bit moves, at most one port is busy and at most one done pulse fires, and a done pulse only follows a busy cycle. They also check that a link-drop teardown never enters the drain wait. Only the bench scenarios can show the order and exact cycle of each control change, the drain length, and port priority. The same holds for the teardown winning over an enable on the same port and for redundant requests vanishing without effect. The bench covers these with directed cases and then with a seeded random series of requests on random ports, each compared against a timeline computed from the requirements.

// File: rtl/portctl_pkg.sv
// Package: shared types for the port bring-up/tear-down sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packed enums.
package portctl_pkg;

    // Which per-port control a step writes.
    typedef enum logic [2:0] {
        CTL_EN    = 3'd0,
        CTL_TXF   = 3'd1,
        CTL_FLUSH = 3'd2,
        CTL_MAC   = 3'd3,
        CTL_RXF   = 3'd4
    } ctl_e;

    // Sequencer states: teardown steps (D_*) and bring-up steps (E_*).
    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_D_EN    = 4'd1,
        ST_D_TXF   = 4'd2,
        ST_D_WAIT  = 4'd3,
        ST_D_FLUSH = 4'd4,
        ST_D_MAC   = 4'd5,
        ST_D_RXF   = 4'd6,
        ST_E_EN    = 4'd7,
        ST_E_TXF   = 4'd8,
        ST_E_FLUSH = 4'd9,
        ST_E_MAC   = 4'd10,
        ST_E_RXF   = 4'd11
    } seq_state_e;

endpackage

// File: rtl/portctl_req_store.sv
// Module: portctl_req_store
// Holds one pending flag per port for each request kind and selects the
// lowest-numbered port with anything pending. The caller clears a port's
// flags with clr_i when it takes that port; a request that arrives in the
// same cycle as the clear is kept.
// Assumes: requests are one-cycle pulses; clr_i is one-hot or zero.
module portctl_req_store #(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] en_req_i,
    input  logic [NUM_PORTS-1:0] dis_req_i,
    input  logic [NUM_PORTS-1:0] ld_req_i,
    input  logic [NUM_PORTS-1:0] clr_i,
    output logic                 sel_valid_o,
    output logic [PW-1:0]        sel_port_o,
    output logic                 sel_dis_o,
    output logic                 sel_ld_o
);

    logic [NUM_PORTS-1:0] en_q;
    logic [NUM_PORTS-1:0] dis_q;
    logic [NUM_PORTS-1:0] ld_q;
    logic [NUM_PORTS-1:0] any_pend;

    // One set of pending flops per port.
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_pend
        // Capture request pulses; a clear drops older flags but keeps new arrivals.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[gi]  <= 1'b0;
                dis_q[gi] <= 1'b0;
                ld_q[gi]  <= 1'b0;
            end else if (clr_i[gi]) begin
                en_q[gi]  <= en_req_i[gi];
                dis_q[gi] <= dis_req_i[gi];
                ld_q[gi]  <= ld_req_i[gi];
            end else begin
                en_q[gi]  <= en_q[gi]  | en_req_i[gi];
                dis_q[gi] <= dis_q[gi] | dis_req_i[gi];
                ld_q[gi]  <= ld_q[gi]  | ld_req_i[gi];
            end
        end
    end

    assign any_pend = en_q | dis_q | ld_q;

    // Fixed priority: the lowest index with a pending flag wins.
    always_comb begin
        sel_valid_o = 1'b0;
        sel_port_o  = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (any_pend[i]) begin
                sel_valid_o = 1'b1;
                sel_port_o  = PW'(i);
            end
        end
    end

    // Teardown (either kind) outranks enable for the selected port.
    assign sel_dis_o = dis_q[sel_port_o] | ld_q[sel_port_o];
    assign sel_ld_o  = ld_q[sel_port_o];

    // R8: the selected port really has something pending.
    assert_sel_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> any_pend[sel_port_o]);

    // R9: a cleared port whose flags were older than this cycle holds no enable afterwards unless re-requested.
    assert_clear_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((en_q & $past(clr_i) & ~$past(en_req_i)) == '0));

endmodule

// File: rtl/portctl_drain_timer.sv
// Module: portctl_drain_timer
// Down-counter for the teardown drain wait. start_i loads DRAIN_CYCLES;
// expired_o is high when the count has reached zero. A wait state entered
// right after start therefore lasts DRAIN_CYCLES+1 cycles.
// Assumes: start_i is not asserted while a wait is in progress.
module portctl_drain_timer #(
    parameter int DRAIN_CYCLES = 16,
    parameter int CW           = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);

    logic [CW-1:0] cnt_q;

    // Load on start, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(DRAIN_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: a start with a nonzero drain holds expiry off for the next cycle.
    assert_drain_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && DRAIN_CYCLES > 0) |=> !expired_o);

endmodule

// File: rtl/portctl_ctrl_regs.sv
// Module: portctl_ctrl_regs
// Owns the five per-port control vectors. Each cycle at most one command
// writes one bit of one vector. Reset leaves every port down: enable clear,
// every soft reset and the flush asserted.
// Assumes: cmd_port_i < NUM_PORTS whenever cmd_valid_i is high.
module portctl_ctrl_regs
    import portctl_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid_i,
    input  ctl_e                 cmd_ctl_i,
    input  logic                 cmd_val_i,
    input  logic [PW-1:0]        cmd_port_i,
    input  logic [NUM_PORTS-1:0] busy_i,
    output logic [NUM_PORTS-1:0] port_en_o,
    output logic [NUM_PORTS-1:0] txf_rst_o,
    output logic [NUM_PORTS-1:0] tx_flush_o,
    output logic [NUM_PORTS-1:0] mac_rst_o,
    output logic [NUM_PORTS-1:0] rxf_rst_o
);

    localparam int ALLW = 5 * NUM_PORTS;

    logic [ALLW-1:0] all_ctl;

    // Apply one bit write per cycle from the step command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_o  <= '0;
            txf_rst_o  <= '1;
            tx_flush_o <= '1;
            mac_rst_o  <= '1;
            rxf_rst_o  <= '1;
        end else if (cmd_valid_i) begin
            case (cmd_ctl_i)
                CTL_EN:    port_en_o[cmd_port_i]  <= cmd_val_i;
                CTL_TXF:   txf_rst_o[cmd_port_i]  <= cmd_val_i;
                CTL_FLUSH: tx_flush_o[cmd_port_i] <= cmd_val_i;
                CTL_MAC:   mac_rst_o[cmd_port_i]  <= cmd_val_i;
                CTL_RXF:   rxf_rst_o[cmd_port_i]  <= cmd_val_i;
                default:   ;
            endcase
        end
    end

    assign all_ctl = {port_en_o, txf_rst_o, tx_flush_o, mac_rst_o, rxf_rst_o};

    // R6: never more than one control bit moves in a cycle.
    assert_one_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(all_ctl ^ $past(all_ctl)) <= 1);

    // R6: controls only move while some port's sequence is running.
    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ctl != $past(all_ctl)) |-> ($past(busy_i) != '0));

endmodule

// File: rtl/portctl_step_fsm.sv
// Module: portctl_step_fsm
// Takes the selected port from the request store and walks it through the
// bring-up or teardown steps, issuing one control write per step. A request
// that matches the port's present enable level is dropped in one idle cycle.
// The teardown waits for the drain timer unless a link drop caused it.
// Assumes: port_en_i reflects the control registers fed by this FSM.
module portctl_step_fsm
    import portctl_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_valid_i,
    input  logic [PW-1:0]        sel_port_i,
    input  logic                 sel_dis_i,
    input  logic                 sel_ld_i,
    input  logic [NUM_PORTS-1:0] port_en_i,
    input  logic                 tmr_expired_i,
    output logic [NUM_PORTS-1:0] clr_o,
    output logic                 tmr_start_o,
    output logic                 cmd_valid_o,
    output ctl_e                 cmd_ctl_o,
    output logic                 cmd_val_o,
    output logic [PW-1:0]        cmd_port_o,
    output logic [NUM_PORTS-1:0] busy_o,
    output logic [NUM_PORTS-1:0] done_o
);

    seq_state_e           state_q, state_d;
    logic [PW-1:0]        port_q;
    logic                 skip_q;
    logic [NUM_PORTS-1:0] done_q;
    logic [NUM_PORTS-1:0] cur_oh;
    logic [NUM_PORTS-1:0] sel_oh;
    logic                 start_seq;
    logic                 redundant;
    logic                 last_step;

    // One-hot decode of the running and the selected port.
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_oh
        assign cur_oh[gi] = (port_q == PW'(gi));
        assign sel_oh[gi] = (sel_port_i == PW'(gi));
    end

    // A teardown of a down port or a bring-up of an up port does nothing.
    assign redundant = sel_dis_i ? !port_en_i[sel_port_i] : port_en_i[sel_port_i];
    assign start_seq = (state_q == ST_IDLE) && sel_valid_i && !redundant;
    assign clr_o     = ((state_q == ST_IDLE) && sel_valid_i) ? sel_oh : '0;
    assign last_step = (state_q == ST_D_RXF) || (state_q == ST_E_RXF);

    // Next-state and per-step command decode.
    always_comb begin
        state_d     = state_q;
        cmd_valid_o = 1'b0;
        cmd_ctl_o   = CTL_EN;
        cmd_val_o   = 1'b0;
        tmr_start_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_seq) state_d = sel_dis_i ? ST_D_EN : ST_E_EN;
            end
            ST_D_EN: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_EN;    cmd_val_o = 1'b0;
                state_d     = ST_D_TXF;
            end
            ST_D_TXF: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_TXF;   cmd_val_o = 1'b1;
                tmr_start_o = !skip_q;
                state_d     = skip_q ? ST_D_FLUSH : ST_D_WAIT;
            end
            ST_D_WAIT: begin
                if (tmr_expired_i) state_d = ST_D_FLUSH;
            end
            ST_D_FLUSH: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_FLUSH; cmd_val_o = 1'b1;
                state_d     = ST_D_MAC;
            end
            ST_D_MAC: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_MAC;   cmd_val_o = 1'b1;
                state_d     = ST_D_RXF;
            end
            ST_D_RXF: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_RXF;   cmd_val_o = 1'b1;
                state_d     = ST_IDLE;
            end
            ST_E_EN: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_EN;    cmd_val_o = 1'b1;
                state_d     = ST_E_TXF;
            end
            ST_E_TXF: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_TXF;   cmd_val_o = 1'b0;
                state_d     = ST_E_FLUSH;
            end
            ST_E_FLUSH: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_FLUSH; cmd_val_o = 1'b0;
                state_d     = ST_E_MAC;
            end
            ST_E_MAC: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_MAC;   cmd_val_o = 1'b0;
                state_d     = ST_E_RXF;
            end
            ST_E_RXF: begin
                cmd_valid_o = 1'b1; cmd_ctl_o = CTL_RXF;   cmd_val_o = 1'b0;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched port, link-drop flag and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            skip_q  <= 1'b0;
            done_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= last_step ? cur_oh : '0;
            if (start_seq) begin
                port_q <= sel_port_i;
                skip_q <= sel_ld_i;
            end
        end
    end

    assign cmd_port_o = port_q;
    assign busy_o     = (state_q != ST_IDLE) ? cur_oh : '0;
    assign done_o     = done_q;

    // R7: only one port is ever in sequence.
    assert_single_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_o));

    // R11: at most one done pulse, and only right after a busy cycle of that port.
    assert_done_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> (($past(busy_o) & done_o) == done_o));

    // R11: a done pulse lasts exactly one cycle.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |=> ((done_o & $past(done_o)) == '0));

    // R5: a link-drop teardown never sits in the drain wait.
    assert_no_wait_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D_WAIT) |-> !skip_q);

endmodule

// File: rtl/portctl_sequencer.sv
// Module: portctl_sequencer (top)
// Per-port enable/disable control sequencer for a multi-port MAC. It queues
// enable, disable and link-drop pulses per port, serves one port at a time
// in fixed priority, and moves that port's controls one bit per step.
// Assumes: synchronous active-low reset; request inputs are one-cycle pulses
// already synchronous to clk.
module portctl_sequencer #(
    parameter int NUM_PORTS    = 4,
    parameter int DRAIN_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] en_req_i,
    input  logic [NUM_PORTS-1:0] dis_req_i,
    input  logic [NUM_PORTS-1:0] link_drop_i,
    output logic [NUM_PORTS-1:0] port_en_o,
    output logic [NUM_PORTS-1:0] txf_rst_o,
    output logic [NUM_PORTS-1:0] tx_flush_o,
    output logic [NUM_PORTS-1:0] mac_rst_o,
    output logic [NUM_PORTS-1:0] rxf_rst_o,
    output logic [NUM_PORTS-1:0] busy_o,
    output logic [NUM_PORTS-1:0] done_o
);

    import portctl_pkg::*;

    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CW = (DRAIN_CYCLES > 0) ? $clog2(DRAIN_CYCLES + 1) : 1;

    logic                 sel_valid;
    logic [PW-1:0]        sel_port;
    logic                 sel_dis;
    logic                 sel_ld;
    logic [NUM_PORTS-1:0] clr;
    logic                 tmr_start;
    logic                 tmr_expired;
    logic                 cmd_valid;
    ctl_e                 cmd_ctl;
    logic                 cmd_val;
    logic [PW-1:0]        cmd_port;

    portctl_req_store #(
        .NUM_PORTS (NUM_PORTS),
        .PW        (PW)
    ) req_store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req_i    (en_req_i),
        .dis_req_i   (dis_req_i),
        .ld_req_i    (link_drop_i),
        .clr_i       (clr),
        .sel_valid_o (sel_valid),
        .sel_port_o  (sel_port),
        .sel_dis_o   (sel_dis),
        .sel_ld_o    (sel_ld)
    );

    portctl_drain_timer #(
        .DRAIN_CYCLES (DRAIN_CYCLES),
        .CW           (CW)
    ) drain_timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .expired_o (tmr_expired)
    );

    portctl_step_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .PW        (PW)
    ) step_fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_valid_i   (sel_valid),
        .sel_port_i    (sel_port),
        .sel_dis_i     (sel_dis),
        .sel_ld_i      (sel_ld),
        .port_en_i     (port_en_o),
        .tmr_expired_i (tmr_expired),
        .clr_o         (clr),
        .tmr_start_o   (tmr_start),
        .cmd_valid_o   (cmd_valid),
        .cmd_ctl_o     (cmd_ctl),
        .cmd_val_o     (cmd_val),
        .cmd_port_o    (cmd_port),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    portctl_ctrl_regs #(
        .NUM_PORTS (NUM_PORTS),
        .PW        (PW)
    ) ctrl_regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_ctl_i   (cmd_ctl),
        .cmd_val_i   (cmd_val),
        .cmd_port_i  (cmd_port),
        .busy_i      (busy_o),
        .port_en_o   (port_en_o),
        .txf_rst_o   (txf_rst_o),
        .tx_flush_o  (tx_flush_o),
        .mac_rst_o   (mac_rst_o),
        .rxf_rst_o   (rxf_rst_o)
    );

    // R1: reset value seen by the cycle right after reset is released.
    assert_reset_state_R1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (port_en_o == '0 && txf_rst_o == '1 &&
                                      tx_flush_o == '1 && mac_rst_o == '1 &&
                                      rxf_rst_o == '1 && busy_o == '0));

endmodule

// File: tb/portctl_sequencer_tb_top.sv
// Bench for portctl_sequencer: directed corner cases followed by seeded
// random requests, each checked cycle by cycle against a timeline computed
// from the requirements.
module portctl_sequencer_tb_top;

    localparam int N     = 4;
    localparam int DRAIN = 6;
    localparam int VW    = 5 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] en_req = '0;
    logic [N-1:0] dis_req = '0;
    logic [N-1:0] ld_req = '0;
    logic [N-1:0] port_en, txf_rst, tx_flush, mac_rst, rxf_rst, busy, done;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    // Bench model of each port's control levels.
    logic [N-1:0] m_en, m_txf, m_fl, m_mac, m_rx;

    portctl_sequencer #(
        .NUM_PORTS    (N),
        .DRAIN_CYCLES (DRAIN)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req_i    (en_req),
        .dis_req_i   (dis_req),
        .link_drop_i (ld_req),
        .port_en_o   (port_en),
        .txf_rst_o   (txf_rst),
        .tx_flush_o  (tx_flush),
        .mac_rst_o   (mac_rst),
        .rxf_rst_o   (rxf_rst),
        .busy_o      (busy),
        .done_o      (done)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            n_fail = n_fail + 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] model_vec();
        return {m_en, m_txf, m_fl, m_mac, m_rx};
    endfunction

    function automatic logic [VW-1:0] dut_vec();
        return {port_en, txf_rst, tx_flush, mac_rst, rxf_rst};
    endfunction

    // kind: 0 bring-up, 1 teardown with drain, 2 teardown without drain.
    function automatic int last_k(input int kind);
        return (kind == 1) ? 8 + DRAIN : 7;
    endfunction

    // Steps visible k cycles after the request cycle.
    function automatic int steps_at(input int kind, input int k);
        int s;
        if (kind == 1) begin
            if (k < 6 + DRAIN) s = (k - 2 > 2) ? 2 : k - 2;
            else               s = k - 3 - DRAIN;
        end else begin
            s = k - 2;
        end
        if (s < 0) s = 0;
        if (s > 5) s = 5;
        return s;
    endfunction

    // Model vector with port p moved forward by s steps of the given kind.
    function automatic logic [VW-1:0] exp_vec(input int p, input int kind, input int s);
        logic [N-1:0] e, t, f, m, r;
        e = m_en; t = m_txf; f = m_fl; m = m_mac; r = m_rx;
        if (kind == 0) begin
            e[p] = (s >= 1);  t[p] = !(s >= 2); f[p] = !(s >= 3);
            m[p] = !(s >= 4); r[p] = !(s >= 5);
        end else begin
            e[p] = !(s >= 1); t[p] = (s >= 2);  f[p] = (s >= 3);
            m[p] = (s >= 4);  r[p] = (s >= 5);
        end
        return {e, t, f, m, r};
    endfunction

    task automatic commit(input int p, input int kind);
        logic [VW-1:0] v;
        v = exp_vec(p, kind, 5);
        {m_en, m_txf, m_fl, m_mac, m_rx} = v;
    endtask

    // Present the pulses, then check every cycle of the sequence.
    task automatic run_seq(input int p, input bit de, input bit dd, input bit dl,
                           input int kind, input string tag);
        int L;
        L = last_k(kind);
        @(negedge clk);
        en_req[p] = de; dis_req[p] = dd; ld_req[p] = dl;
        for (int k = 1; k <= L + 1; k++) begin
            @(negedge clk);
            en_req = '0; dis_req = '0; ld_req = '0;
            check(tag, dut_vec(), exp_vec(p, kind, steps_at(kind, k)));
            check("R11 busy", VW'(busy), VW'((k >= 2 && k <= L - 1) ? (1 << p) : 0));
            check("R11 done", VW'(done), VW'((k == L) ? (1 << p) : 0));
        end
        commit(p, kind);
    endtask

    // Present pulses that must have no effect; watch the ports for a while.
    task automatic run_nothing(input int p, input bit de, input bit dd, input bit dl,
                               input string tag);
        @(negedge clk);
        en_req[p] = de; dis_req[p] = dd; ld_req[p] = dl;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            en_req = '0; dis_req = '0; ld_req = '0;
            check(tag, dut_vec(), model_vec());
            check({tag, " busy/done"}, VW'({busy, done}), '0);
        end
    endtask

    initial begin
        m_en = '0; m_txf = '1; m_fl = '1; m_mac = '1; m_rx = '1;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R1: state during reset.
        check("R1 in reset", dut_vec(), model_vec());
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", dut_vec(), model_vec());
        check("R1 busy/done", VW'({busy, done}), '0);

        // R8: ports 2 and 1 request together; port 1 first, port 2 one cycle after its done.
        @(negedge clk);
        en_req = 4'b0110;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            en_req = '0;
            if (k == 2)  check("R8 first busy", VW'(busy), VW'(4'b0010));
            if (k == 7)  check("R8 first done", VW'(done), VW'(4'b0010));
            if (k == 8)  check("R8 second busy", VW'(busy), VW'(4'b0100));
            if (k == 13) check("R8 second done", VW'(done), VW'(4'b0100));
        end
        commit(1, 0);
        commit(2, 0);
        check("R8 both up", dut_vec(), model_vec());

        // R2: plain bring-up of ports 0 and 3.
        run_seq(0, 1, 0, 0, 0, "R2 enable p0");
        run_seq(3, 1, 0, 0, 0, "R2 enable p3");

        // R3, R4: teardown with drain on port 2.
        run_seq(2, 0, 1, 0, 1, "R3 R4 disable p2");

        // R5: link drop on port 1 skips the drain.
        run_seq(1, 0, 0, 1, 2, "R5 link drop p1");

        // R9: enable and link drop together on up port 0: teardown, no drain.
        run_seq(0, 1, 0, 1, 2, "R9 drop beats enable p0");

        // R9: the same pair on the now-down port 0 does nothing.
        run_nothing(0, 1, 0, 1, "R9 drop beats enable on down p0");

        // R10: redundant enable on up port 3 and redundant disable on down port 2.
        run_nothing(3, 1, 0, 0, "R10 enable on up p3");
        run_nothing(2, 0, 1, 0, "R10 disable on down p2");
        run_nothing(1, 0, 0, 1, "R10 link drop on down p1");

        // Random series of single requests.
        for (int it = 0; it < 60; it++) begin
            int p;
            int r;
            p = int'($urandom % N);
            r = int'($urandom % 3);
            if (r == 0) begin
                if (m_en[p]) run_nothing(p, 1, 0, 0, "R10 random enable");
                else         run_seq(p, 1, 0, 0, 0, "R2 random enable");
            end else if (r == 1) begin
                if (!m_en[p]) run_nothing(p, 0, 1, 0, "R10 random disable");
                else          run_seq(p, 0, 1, 0, 1, "R3 R4 random disable");
            end else begin
                if (!m_en[p]) run_nothing(p, 0, 0, 1, "R10 random link drop");
                else          run_seq(p, 0, 0, 1, 2, "R5 random link drop");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule